// File: doc/BRIEF.md
# Pipelined Converter Code Corrector

This block sits behind the comparator bank of a nine-stage pipelined analog-to-digital converter. It turns the coarse per-stage decisions into one 10-bit sample. The first eight stages each resolve 1.5 bits, giving a three-valued decision. The last stage is a 2-bit flash. A sample moves one stage further along the pipeline every half period of the sample clock. As a result, the nine decisions for one sample reach the block at nine different times.

The block runs on a clock at twice the sample rate, so one clock edge is one half-cycle tick. An internal phase toggle marks which ticks are sample instants. Each stage's decision is captured and then delayed by its own depth, so that all nine decisions for a sample meet at the same tick. There they are summed with a one-bit overlap between neighbouring stage weights. This redundancy absorbs comparator threshold errors. The sum is then held in an output register for one full sample period.

Top module: `pipe_code_corrector`

## Requirements
- R1: `stage_code_i` carries stage k (k = 1..9) in bits [2k-1:2k-2]. Stages 1 to 8 use the values 0, 1 and 2. Stage 9 uses 0 to 3.
- R2: The output word equals the sum of d_k·2^(9−k) for stages k = 1..8, plus d_9, where each d_k is the decision that belongs to the same sample. The word ranges over 0..1023.
- R3: Tick 0 is the first rising edge with `rst_n` high, and samples are taken on the even ticks. For the sample at tick t, stage k's decision is captured at edge t+k.
- R4: The word for the sample at tick t appears after edge t+10, which is five sample periods. `word_valid_o` is high for exactly that one tick.
- R5: `word_valid_o` stays low after the first ten edges following reset and on every odd tick. `word_o` holds its value through the tick that follows a valid tick.
- R6: Nominal comparator thresholds sit at ±1/4 of the stage input span [-1,1). If any threshold of stages 1 to 8 is moved by up to ±3/16, the word still equals floor(512·(vin+1)). Every code from 0 to 1023 appears.
- R7: Decisions presented on the ticks where they belong to no sample have no effect on any output word.
- R8: The value 3 on any of stages 1 to 8 sets `code_err_o` after that edge. The flag stays set until reset. The value 3 on stage 9 never sets it.
- R9: While `rst_n` is low at a clock edge, the outputs become `word_o` = 0, `word_valid_o` = 0 and `code_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle tick clock (twice the sample rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_code_i | input | 18 | Packed per-stage decisions, stage k in bits [2k-1:2k-2] |
| word_o | output | 10 | Corrected sample word |
| word_valid_o | output | 1 | One-tick strobe marking a new word |
| code_err_o | output | 1 | Sticky flag for an illegal decision on stages 1 to 8 |

## Verification
The bench sweeps all 8192 input levels of a behavioural residue model twice. The first sweep uses ideal comparators. The second uses per-stage threshold shifts that push many samples across a decision boundary. Both sweeps expect the plain quantized value, so a wrong weight, a wrong per-stage delay, or a word loaded on the wrong phase shows up as a wrong or missing code.

Random legal decisions fill the ticks that belong to no sample. An alignment that is off by one half-cycle would therefore mix in garbage rather than a neighbouring sample's decision. The bench also checks the length of the fill period and the alternating strobe. Finally, it applies an illegal value on a redundant stage and the value 3 on the last stage. A monitor that is not sticky, or that also watches the last stage, fails these checks.

// File: rtl/pcc_pkg.sv
// Shared constants and types for the pipelined converter code corrector.
package pcc_pkg;
    localparam int CODE_W = 2;
    typedef logic [CODE_W-1:0] stage_code_t;
    // Decision value that no redundant (1.5-bit) stage may produce.
    localparam stage_code_t CODE_ILLEGAL = 2'd3;
endpackage

// File: rtl/pcc_phase_ctl.sv
// Phase and fill control.
// Toggles a phase bit on every tick so that even ticks are sample instants.
// Counts ticks after reset up to LAT_TICKS. From then on it requests an
// output load on every even tick.
// Assumes: one clk edge = one half-cycle of the sample clock.
module pcc_phase_ctl #(
    parameter int LAT_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o
);
    localparam int CNT_W = $clog2(LAT_TICKS + 1);

    logic             phase_q;
    logic [CNT_W-1:0] fill_q;
    logic             fill_done;

    assign fill_done = (fill_q == CNT_W'(LAT_TICKS));
    assign load_o    = fill_done && !phase_q;

    // Advance the phase and the saturating fill counter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            fill_q  <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (!fill_done) begin
                fill_q <= fill_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pcc_stage_align.sv
// Per-stage alignment delay.
// Captures one stage's decision on every tick and delays it by DEPTH further
// ticks. All stages then present decisions of the same sample together.
// Assumes: DEPTH >= 0; a depth of zero leaves only the capture register.
module pcc_stage_align
    import pcc_pkg::*;
#(
    parameter int DEPTH = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  stage_code_t code_i,
    output stage_code_t code_o
);
    stage_code_t chain_q [DEPTH+1];

    // Shift the decision through the capture register and the delay taps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= DEPTH; i++) begin
                chain_q[i] <= '0;
            end
        end else begin
            chain_q[0] <= code_i;
            for (int i = 1; i <= DEPTH; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign code_o = chain_q[DEPTH];
endmodule

// File: rtl/pcc_overlap_adder.sv
// Overlap adder.
// Weights aligned stage k (k = 1..NUM_STAGES-1) by 2^(NUM_STAGES-k) and adds
// the last stage with weight 1. Neighbouring weights overlap by one bit, which
// is what lets a redundant decision be corrected by the next stage.
// Assumes: redundant decisions are 0..2 and the last one is 0..3; the sum then
// fits in OUT_W bits without clamping.
module pcc_overlap_adder
    import pcc_pkg::*;
#(
    parameter int NUM_STAGES = 9,
    parameter int OUT_W      = NUM_STAGES + 1
) (
    input  logic [NUM_STAGES*CODE_W-1:0] aligned_i,
    output logic [OUT_W-1:0]             sum_o
);
    // Accumulate the shifted stage decisions.
    always_comb begin
        logic [OUT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_STAGES - 1; i++) begin
            acc = acc + (OUT_W'(aligned_i[i*CODE_W +: CODE_W]) << (NUM_STAGES - 1 - i));
        end
        acc   = acc + OUT_W'(aligned_i[(NUM_STAGES-1)*CODE_W +: CODE_W]);
        sum_o = acc;
    end
endmodule

// File: rtl/pcc_code_monitor.sv
// Illegal-decision monitor.
// Raises a sticky flag when any redundant stage presents the reserved value.
// The last (flash) stage may legally use every value and is not watched.
// Assumes: the flag is cleared only by reset.
module pcc_code_monitor
    import pcc_pkg::*;
#(
    parameter int NUM_STAGES = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_STAGES*CODE_W-1:0] codes_i,
    output logic                         err_o
);
    logic bad;

    // Look for the reserved value on the redundant stages.
    always_comb begin
        bad = 1'b0;
        for (int i = 0; i < NUM_STAGES - 1; i++) begin
            if (codes_i[i*CODE_W +: CODE_W] == CODE_ILLEGAL) begin
                bad = 1'b1;
            end
        end
    end

    // Keep the flag set once raised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (bad) begin
            err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pipe_code_corrector.sv
// Pipelined converter code corrector (top).
// Aligns nine staggered stage decisions, overlap-adds them and registers the
// corrected word once per sample period, with a one-tick valid strobe.
// Assumes: clk runs at twice the sample rate, and stage k's decision for the
// sample at tick t is present at edge t+k.
module pipe_code_corrector
    import pcc_pkg::*;
#(
    parameter int NUM_STAGES = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_STAGES*CODE_W-1:0] stage_code_i,
    output logic [NUM_STAGES:0]          word_o,
    output logic                         word_valid_o,
    output logic                         code_err_o
);
    localparam int OUT_W     = NUM_STAGES + 1;
    localparam int LAT_TICKS = NUM_STAGES + 1;

    logic [NUM_STAGES*CODE_W-1:0] aligned;
    logic [OUT_W-1:0]             sum;
    logic                         load;
    logic [OUT_W-1:0]             word_q;
    logic                         valid_q;

    pcc_phase_ctl #(
        .LAT_TICKS(LAT_TICKS)
    ) phase_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load_o(load)
    );

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        pcc_stage_align #(
            .DEPTH(NUM_STAGES - 1 - g)
        ) align_i (
            .clk   (clk),
            .rst_n (rst_n),
            .code_i(stage_code_i[g*CODE_W +: CODE_W]),
            .code_o(aligned[g*CODE_W +: CODE_W])
        );
    end

    pcc_overlap_adder #(
        .NUM_STAGES(NUM_STAGES),
        .OUT_W     (OUT_W)
    ) adder_i (
        .aligned_i(aligned),
        .sum_o    (sum)
    );

    pcc_code_monitor #(
        .NUM_STAGES(NUM_STAGES)
    ) mon_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .codes_i(stage_code_i),
        .err_o  (code_err_o)
    );

    // Output latch: take the corrected word on sample-instant ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) begin
                word_q <= sum;
            end
        end
    end

    assign word_o       = word_q;
    assign word_valid_o = valid_q;
endmodule

// File: rtl/pipe_code_corrector_chk.sv
// Property checker for pipe_code_corrector, attached by bind.
// Keeps its own count of ticks since reset, so that it does not depend on
// the design's fill counter.
module pipe_code_corrector_chk
    import pcc_pkg::*;
#(
    parameter int NUM_STAGES = 9
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_STAGES*CODE_W-1:0] stage_code_i,
    input logic [NUM_STAGES:0]          word_o,
    input logic                         word_valid_o,
    input logic                         code_err_o
);
    localparam int LAT   = NUM_STAGES + 1;
    localparam int CNT_W = $clog2(LAT + 2);

    logic [CNT_W-1:0] ticks_q;
    logic             bad_in;

    // Count edges since reset, saturating at LAT+1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_q <= '0;
        end else if (ticks_q != CNT_W'(LAT + 1)) begin
            ticks_q <= ticks_q + CNT_W'(1);
        end
    end

    // Detect an illegal decision on a redundant stage.
    always_comb begin
        bad_in = 1'b0;
        for (int i = 0; i < NUM_STAGES - 1; i++) begin
            if (stage_code_i[i*CODE_W +: CODE_W] == CODE_ILLEGAL) begin
                bad_in = 1'b1;
            end
        end
    end

    assert_fill_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks_q <= CNT_W'(LAT)) |-> !word_valid_o);

    assert_valid_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> $stable(word_o));

    assert_valid_cadence_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ticks_q == CNT_W'(LAT + 1)) && !word_valid_o) |=> word_valid_o);

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_in |=> code_err_o);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |=> code_err_o);

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (!word_valid_o && !code_err_o && (word_o == '0)));
endmodule

bind pipe_code_corrector pipe_code_corrector_chk #(
    .NUM_STAGES(NUM_STAGES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_code_i(stage_code_i),
    .word_o      (word_o),
    .word_valid_o(word_valid_o),
    .code_err_o  (code_err_o)
);

// File: tb/pipe_code_corrector_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every input level through a behavioural residue model, drives
// the staggered decisions and compares the words against plain quantization.
module pipe_code_corrector_tb_top;
    localparam int NS    = 9;
    localparam int NSAMP = 8192;
    localparam int FS    = 4096;
    localparam int LAT   = 10;
    localparam int TICKS = 2 * NSAMP + LAT + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS*2-1:0] bus = '0;
    logic [NS:0]     word;
    logic            vld;
    logic            err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  cd [0:NSAMP-1][1:NS];
    int  off_hi [1:NS-1];
    int  off_lo [1:NS-1];

    always #5 clk = ~clk;

    pipe_code_corrector #(.NUM_STAGES(NS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_code_i(bus),
        .word_o      (word),
        .word_valid_o(vld),
        .code_err_o  (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Residue model: 1.5-bit stages with shifted thresholds, then a 2-bit flash.
    task automatic build_codes();
        for (int s = 0; s < NSAMP; s++) begin
            int v;
            int c;
            v = s - FS;
            for (int k = 1; k < NS; k++) begin
                int d;
                if (v >= FS / 4 + off_hi[k])       d = 2;
                else if (v < -FS / 4 + off_lo[k])  d = 0;
                else                               d = 1;
                cd[s][k] = d;
                v = 2 * v - (d - 1) * FS;
            end
            c = (v + FS) >>> 11;
            if (c > 3) c = 3;
            if (c < 0) c = 0;
            cd[s][NS] = c;
        end
    endtask

    // Synchronous reset; the outputs are checked while reset is held (R9).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(word == '0, "R9 word in reset", int'(word), 0);
        chk(vld == 1'b0, "R9 valid in reset", int'(vld), 0);
        chk(err == 1'b0, "R9 err in reset", int'(err), 0);
        rst_n = 1'b1;
    endtask

    // One full sweep; the tick loop starts at the negedge right after reset.
    task automatic run_sweep(input string tag);
        build_codes();
        do_reset();
        for (int m = 0; m < TICKS; m++) begin
            // Stage k sees sample j/2 at tick j+k (R3); other ticks get filler (R7).
            for (int k = 1; k <= NS; k++) begin
                int j;
                int code;
                j = m - k;
                if (j >= 0 && (j % 2) == 0 && (j / 2) < NSAMP) code = cd[j/2][k];
                else if (k == NS) code = $urandom_range(3, 0);
                else code = $urandom_range(2, 0);
                bus[(k-1)*2 +: 2] = 2'(code);
            end
            @(posedge clk);
            @(negedge clk);
            begin
                bit ev;
                ev = (m >= LAT) && ((m % 2) == 0);
                chk(vld == ev, "R4/R5 valid timing", int'(vld), int'(ev));
                if (ev && ((m - LAT) / 2) < NSAMP) begin
                    int s;
                    s = (m - LAT) / 2;
                    chk(int'(word) == (s >> 3), {tag, " R6 R2 R7 word"}, int'(word), s >> 3);
                end
            end
        end
        chk(err == 1'b0, "R8 R1 no error from legal codes", int'(err), 0);
    endtask

    // Sticky illegal-value flag; the last stage may use 3.
    task automatic run_err();
        do_reset();
        for (int m = 0; m < 3; m++) begin
            for (int k = 1; k < NS; k++) bus[(k-1)*2 +: 2] = 2'd1;
            bus[(NS-1)*2 +: 2] = 2'd3;
            @(posedge clk);
            @(negedge clk);
            chk(err == 1'b0, "R8 stage 9 value 3 legal", int'(err), 0);
        end
        bus[4*2 +: 2] = 2'd3;
        @(posedge clk);
        @(negedge clk);
        chk(err == 1'b1, "R8 stage 5 value 3 flagged", int'(err), 1);
        for (int m = 0; m < 5; m++) begin
            for (int k = 1; k <= NS; k++) bus[(k-1)*2 +: 2] = 2'd2;
            @(posedge clk);
            @(negedge clk);
            chk(err == 1'b1, "R8 flag sticky", int'(err), 1);
        end
        do_reset();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 1; k < NS; k++) begin
            off_hi[k] = 0;
            off_lo[k] = 0;
        end
        run_sweep("ideal");
        for (int k = 1; k < NS; k++) begin
            off_hi[k] = ((k * 397) % 1537) - 768;
            off_lo[k] = ((k * 211 + 500) % 1537) - 768;
        end
        run_sweep("offset");
        run_err();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule